// File: doc/BRIEF.md
# Bus Interrupt Level Evaluator and Vectorer

This block sits between the interrupt request lines of the devices on two peripheral bus adapters and the processor's priority-interrupt (PI) system. It keeps a 32-entry register of pending device requests. Devices set entries with single-cycle pulses, and they withdraw them with clear pulses. Each adapter splits its requests into a high-priority group and a low-priority group. Each group is routed to a PI level taken from the adapter's status fields, which arrive as inputs. The block publishes a one-hot mask of the PI levels that currently have work.

When the processor grants a PI level, it pulses an acknowledge with that level number. The block scans the adapters in ascending order and checks the high group before the low group. It picks the first group that is programmed to the granted level and has a pending request. Inside that group the lowest-numbered pending request wins. That request is cleared, and its interrupt vector and the adapter number (1 or 3) are returned one cycle later. If nothing matches, the block returns vector 0 and adapter 0.

Top module: `bus_irq_router`

## Requirements
- R1: A pulse on `req_set[i]` makes `pending[i]` 1 after that clock edge. When a set and any clear of the same bit (device clear or acknowledge) happen in the same cycle, the set wins.
- R2: A pulse on `req_clr[i]` without a set of the same bit makes `pending[i]` 0 after that clock edge.
- R3: `level_mask` is registered from `pending` and lags it by one cycle. Bit L is 1 when some adapter has a high-group request pending and its high field equals L, or has a low-group request pending and its low field equals L. A field value of 0 means the group is disconnected, so bit 0 is never set.
- R4: After synchronous reset, `pending`, `level_mask` and `rsp_valid` are all 0.
- R5: `rsp_valid` is 1 in exactly the cycle after a cycle with `ack_valid` high, and 0 otherwise.
- R6: On acknowledge, adapters are scanned from index 0 upward. For each adapter the high group is checked before the low group. The first group whose field equals `ack_level` and that has a pending request is selected. An `ack_level` of 0 never matches.
- R7: Within the selected group, the lowest-numbered pending bit wins. That bit is cleared at the acknowledge edge, unless R1 applies. An acknowledge clears at most one bit.
- R8: The reported adapter number is 2*index+1 (1 for adapter 0, 3 for adapter 1). When nothing matches, `rsp_vector` is 0, `rsp_adapter` is 0 and no bit is cleared.
- R9: Default vectors (octal) by request bit: 6 gives 254, 7 gives 224, 16 gives 340, 17 gives 344, 24 gives 070, 25 gives 074, 26 gives 754. Every other bit gives 0.
- R10: Default group membership is as follows. Adapter 0 high group is bits 7:4 and its low group is bits 3:0. Adapter 1 high group is bits 19:16 and 27:24, and its low group is bits 15:8, 23:20 and 31:28. Fields are packed with adapter 0 in bits 2:0 and adapter 1 in bits 5:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | 32 | Per-request set pulses |
| req_clr | input | 32 | Per-request clear pulses |
| pi_hi_lvl | input | 6 | High-group PI level per adapter, 3 bits each |
| pi_lo_lvl | input | 6 | Low-group PI level per adapter, 3 bits each |
| ack_valid | input | 1 | Processor grants a PI level this cycle |
| ack_level | input | 3 | Granted PI level |
| pending | output | 32 | Pending request register |
| level_mask | output | 8 | One-hot-per-level mask of requesting PI levels |
| rsp_valid | output | 1 | Acknowledge response valid |
| rsp_vector | output | 9 | Vector of the winning request, 0 if none |
| rsp_adapter | output | 2 | Adapter number of the winner, 0 if none |

## Verification
If a request bit is stuck, it shows on `pending` at the very next edge. It also shows one edge later on `level_mask` as a phantom or missing level. A wrong scan order or a wrong priority encoder shows in the response that follows a single acknowledge, as a wrong adapter or vector. It also shows in the following cycle as the wrong bit left in `pending`. Because the bench tracks a full reference of the request register and compares every port on every cycle, any divergence is caught within one or two cycles of the stimulus that causes it.

// File: rtl/irq_rt_pkg.sv
`timescale 1ns/1ps
package irq_rt_pkg;

  localparam int unsigned DEF_REQ = 32;
  localparam int unsigned DEF_VW  = 9;

  typedef enum logic {GRP_HI = 1'b0, GRP_LO = 1'b1} grp_e;

  // Default vector table: one VW-wide slot per request bit, slot 0 lowest.
  function automatic logic [DEF_REQ*DEF_VW-1:0] default_vectors();
    logic [DEF_REQ*DEF_VW-1:0] t;
    t = '0;
    t[6*DEF_VW  +: DEF_VW] = 9'o254;
    t[7*DEF_VW  +: DEF_VW] = 9'o224;
    t[16*DEF_VW +: DEF_VW] = 9'o340;
    t[17*DEF_VW +: DEF_VW] = 9'o344;
    t[24*DEF_VW +: DEF_VW] = 9'o070;
    t[25*DEF_VW +: DEF_VW] = 9'o074;
    t[26*DEF_VW +: DEF_VW] = 9'o754;
    return t;
  endfunction

endpackage

// File: rtl/irq_req_reg.sv
`timescale 1ns/1ps
module irq_req_reg #(
  parameter int unsigned NUM_REQ = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] set_i,
  input  logic [NUM_REQ-1:0] clr_i,
  input  logic [NUM_REQ-1:0] ack_clr_i,
  output logic [NUM_REQ-1:0] pend_o
);
  // Set has priority over both kinds of clear.
  always_ff @(posedge clk) begin
    if (rst) pend_o <= '0;
    else     pend_o <= (pend_o & ~clr_i & ~ack_clr_i) | set_i;
  end
endmodule

// File: rtl/irq_level_eval.sv
`timescale 1ns/1ps
module irq_level_eval #(
  parameter int unsigned NUM_REQ = 32,
  parameter int unsigned NUM_ADP = 2,
  parameter int unsigned PI_W    = 3,
  parameter logic [NUM_ADP*NUM_REQ-1:0] HI_MASKS = '0,
  parameter logic [NUM_ADP*NUM_REQ-1:0] LO_MASKS = '0,
  localparam int unsigned NUM_LVL = 1 << PI_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_REQ-1:0]      pend_i,
  input  logic [NUM_ADP*PI_W-1:0] hi_lvl_i,
  input  logic [NUM_ADP*PI_W-1:0] lo_lvl_i,
  output logic [NUM_LVL-1:0]      lvl_o
);
  logic [NUM_ADP-1:0][NUM_LVL-1:0] contrib;
  logic [NUM_LVL-1:0]              lvl_next;

  for (genvar a = 0; a < NUM_ADP; a++) begin : g_adp
    logic [PI_W-1:0]    hl, ll;
    logic               hi_any, lo_any;
    logic [NUM_LVL-1:0] c;
    assign hl     = hi_lvl_i[a*PI_W +: PI_W];
    assign ll     = lo_lvl_i[a*PI_W +: PI_W];
    assign hi_any = |(pend_i & HI_MASKS[a*NUM_REQ +: NUM_REQ]);
    assign lo_any = |(pend_i & LO_MASKS[a*NUM_REQ +: NUM_REQ]);
    always_comb begin
      c = '0;
      // level 0 disconnects a group
      if (hi_any && (hl != '0)) c[hl] = 1'b1;
      if (lo_any && (ll != '0)) c[ll] = 1'b1;
    end
    assign contrib[a] = c;
  end

  always_comb begin
    lvl_next = '0;
    for (int a = 0; a < NUM_ADP; a++) lvl_next = lvl_next | contrib[a];
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_o <= '0;
    else     lvl_o <= lvl_next;
  end
endmodule

// File: rtl/irq_ack_select.sv
`timescale 1ns/1ps
module irq_ack_select
  import irq_rt_pkg::*;
#(
  parameter int unsigned NUM_REQ = 32,
  parameter int unsigned NUM_ADP = 2,
  parameter int unsigned PI_W    = 3,
  parameter logic [NUM_ADP*NUM_REQ-1:0] HI_MASKS = '0,
  parameter logic [NUM_ADP*NUM_REQ-1:0] LO_MASKS = '0,
  localparam int unsigned IDXW = $clog2(NUM_REQ),
  localparam int unsigned ADPW = (NUM_ADP > 1) ? $clog2(NUM_ADP) : 1
) (
  input  logic [NUM_REQ-1:0]      pend_i,
  input  logic [NUM_ADP*PI_W-1:0] hi_lvl_i,
  input  logic [NUM_ADP*PI_W-1:0] lo_lvl_i,
  input  logic [PI_W-1:0]         lvl_i,
  output logic                    hit_o,
  output grp_e                    grp_o,
  output logic [ADPW-1:0]         adp_o,
  output logic [IDXW-1:0]         idx_o
);
  logic [NUM_REQ-1:0] sel_mask;

  // Scan adapters upward, high group before low group; first match wins.
  always_comb begin
    hit_o    = 1'b0;
    grp_o    = GRP_HI;
    adp_o    = '0;
    sel_mask = '0;
    for (int a = 0; a < NUM_ADP; a++) begin
      if (!hit_o && (lvl_i != '0)) begin
        if ((hi_lvl_i[a*PI_W +: PI_W] == lvl_i) &&
            (|(pend_i & HI_MASKS[a*NUM_REQ +: NUM_REQ]))) begin
          hit_o    = 1'b1;
          grp_o    = GRP_HI;
          adp_o    = ADPW'(a);
          sel_mask = pend_i & HI_MASKS[a*NUM_REQ +: NUM_REQ];
        end else if ((lo_lvl_i[a*PI_W +: PI_W] == lvl_i) &&
                     (|(pend_i & LO_MASKS[a*NUM_REQ +: NUM_REQ]))) begin
          hit_o    = 1'b1;
          grp_o    = GRP_LO;
          adp_o    = ADPW'(a);
          sel_mask = pend_i & LO_MASKS[a*NUM_REQ +: NUM_REQ];
        end
      end
    end
  end

  // Lowest-numbered set bit of the selected group.
  always_comb begin
    idx_o = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (sel_mask[i]) idx_o = IDXW'(i);
    end
  end
endmodule

// File: rtl/bus_irq_router.sv
`timescale 1ns/1ps
module bus_irq_router
  import irq_rt_pkg::*;
#(
  parameter int unsigned NUM_REQ = 32,
  parameter int unsigned NUM_ADP = 2,
  parameter int unsigned PI_W    = 3,
  parameter int unsigned VEC_W   = 9,
  parameter logic [NUM_ADP*NUM_REQ-1:0] HI_MASKS = {32'h0F0F_0000, 32'h0000_00F0},
  parameter logic [NUM_ADP*NUM_REQ-1:0] LO_MASKS = {32'hF0F0_FF00, 32'h0000_000F},
  parameter logic [NUM_REQ*VEC_W-1:0]   VEC_TABLE = default_vectors(),
  localparam int unsigned NUM_LVL = 1 << PI_W,
  localparam int unsigned IDXW    = $clog2(NUM_REQ),
  localparam int unsigned ADPW    = (NUM_ADP > 1) ? $clog2(NUM_ADP) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_REQ-1:0]      req_set,
  input  logic [NUM_REQ-1:0]      req_clr,
  input  logic [NUM_ADP*PI_W-1:0] pi_hi_lvl,
  input  logic [NUM_ADP*PI_W-1:0] pi_lo_lvl,
  input  logic                    ack_valid,
  input  logic [PI_W-1:0]         ack_level,
  output logic [NUM_REQ-1:0]      pending,
  output logic [NUM_LVL-1:0]      level_mask,
  output logic                    rsp_valid,
  output logic [VEC_W-1:0]        rsp_vector,
  output logic [ADPW:0]           rsp_adapter
);
  logic               sel_hit;
  grp_e               sel_grp;
  logic [ADPW-1:0]    sel_adp;
  logic [IDXW-1:0]    sel_idx;
  logic [NUM_REQ-1:0] ack_clr;

  irq_req_reg #(.NUM_REQ(NUM_REQ)) u_req (
    .clk(clk), .rst(rst), .set_i(req_set), .clr_i(req_clr),
    .ack_clr_i(ack_clr), .pend_o(pending)
  );

  irq_level_eval #(
    .NUM_REQ(NUM_REQ), .NUM_ADP(NUM_ADP), .PI_W(PI_W),
    .HI_MASKS(HI_MASKS), .LO_MASKS(LO_MASKS)
  ) u_lvl (
    .clk(clk), .rst(rst), .pend_i(pending),
    .hi_lvl_i(pi_hi_lvl), .lo_lvl_i(pi_lo_lvl), .lvl_o(level_mask)
  );

  irq_ack_select #(
    .NUM_REQ(NUM_REQ), .NUM_ADP(NUM_ADP), .PI_W(PI_W),
    .HI_MASKS(HI_MASKS), .LO_MASKS(LO_MASKS)
  ) u_sel (
    .pend_i(pending), .hi_lvl_i(pi_hi_lvl), .lo_lvl_i(pi_lo_lvl),
    .lvl_i(ack_level), .hit_o(sel_hit), .grp_o(sel_grp),
    .adp_o(sel_adp), .idx_o(sel_idx)
  );

  always_comb begin
    ack_clr = '0;
    if (ack_valid && sel_hit) ack_clr[sel_idx] = 1'b1;
  end

  // Registered acknowledge response; the group is informational only.
  logic grp_unused;
  assign grp_unused = (sel_grp == GRP_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_vector  <= '0;
      rsp_adapter <= '0;
    end else begin
      rsp_valid <= ack_valid;
      if (ack_valid) begin
        if (sel_hit) begin
          rsp_vector  <= VEC_TABLE[sel_idx*VEC_W +: VEC_W];
          rsp_adapter <= {sel_adp, 1'b1};
        end else begin
          rsp_vector  <= '0;
          rsp_adapter <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
`timescale 1ns/1ps
module irq_router_chk #(
  parameter int unsigned NUM_REQ = 32,
  parameter int unsigned NUM_ADP = 2,
  parameter int unsigned PI_W    = 3,
  parameter int unsigned VEC_W   = 9,
  localparam int unsigned NUM_LVL = 1 << PI_W,
  localparam int unsigned ADPW    = (NUM_ADP > 1) ? $clog2(NUM_ADP) : 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_REQ-1:0]      req_set,
  input logic [NUM_REQ-1:0]      req_clr,
  input logic [NUM_ADP*PI_W-1:0] pi_hi_lvl,
  input logic [NUM_ADP*PI_W-1:0] pi_lo_lvl,
  input logic                    ack_valid,
  input logic [NUM_REQ-1:0]      pending,
  input logic [NUM_LVL-1:0]      level_mask,
  input logic                    rsp_valid,
  input logic [VEC_W-1:0]        rsp_vector,
  input logic [ADPW:0]           rsp_adapter
);
  assert_set_wins_R1: assert property (@(posedge clk) disable iff (rst)
    (req_set != '0) |=> ((pending & $past(req_set)) == $past(req_set)));

  assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
    ((req_clr & ~req_set) != '0) |=> ((pending & $past(req_clr & ~req_set)) == '0));

  assert_no_level0_R3: assert property (@(posedge clk) disable iff (rst)
    !level_mask[0]);

  assert_idle_levels_R3: assert property (@(posedge clk) disable iff (rst)
    (pending == '0) |=> (level_mask == '0));

  assert_fields_off_R3: assert property (@(posedge clk) disable iff (rst)
    ((pi_hi_lvl == '0) && (pi_lo_lvl == '0)) |=> (level_mask == '0));

  assert_rsp_follows_R5: assert property (@(posedge clk) disable iff (rst)
    ack_valid |=> rsp_valid);

  assert_rsp_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !ack_valid |=> !rsp_valid);

  assert_single_clear_R7: assert property (@(posedge clk) disable iff (rst)
    ack_valid |=> ($countones($past(pending) & ~pending & ~$past(req_clr)) <= 1));

  assert_adapter_odd_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ((rsp_adapter == '0) || rsp_adapter[0]));

  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_adapter == '0)) |-> (rsp_vector == '0));
endmodule

bind bus_irq_router irq_router_chk #(
  .NUM_REQ(NUM_REQ), .NUM_ADP(NUM_ADP), .PI_W(PI_W), .VEC_W(VEC_W)
) chk_i (
  .clk(clk), .rst(rst), .req_set(req_set), .req_clr(req_clr),
  .pi_hi_lvl(pi_hi_lvl), .pi_lo_lvl(pi_lo_lvl), .ack_valid(ack_valid),
  .pending(pending), .level_mask(level_mask), .rsp_valid(rsp_valid),
  .rsp_vector(rsp_vector), .rsp_adapter(rsp_adapter)
);

// File: tb/bus_irq_router_tb.sv
`timescale 1ns/1ps
module bus_irq_router_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] req_set, req_clr;
  logic [5:0]  pi_hi_lvl, pi_lo_lvl;
  logic        ack_valid;
  logic [2:0]  ack_level;
  logic [31:0] pending;
  logic [7:0]  level_mask;
  logic        rsp_valid;
  logic [8:0]  rsp_vector;
  logic [1:0]  rsp_adapter;

  always #10 clk = ~clk;

  bus_irq_router dut_i (
    .clk(clk), .rst(rst), .req_set(req_set), .req_clr(req_clr),
    .pi_hi_lvl(pi_hi_lvl), .pi_lo_lvl(pi_lo_lvl), .ack_valid(ack_valid),
    .ack_level(ack_level), .pending(pending), .level_mask(level_mask),
    .rsp_valid(rsp_valid), .rsp_vector(rsp_vector), .rsp_adapter(rsp_adapter)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [2:0]  hl [2];
  logic [2:0]  ll [2];
  logic [31:0] m_pend;
  logic [7:0]  exp_lvl;
  logic [8:0]  exp_vec;
  logic [1:0]  exp_adp;
  logic        exp_rv;

  assign pi_hi_lvl = {hl[1], hl[0]};
  assign pi_lo_lvl = {ll[1], ll[0]};

  // Group membership per R10
  function automatic logic [31:0] hi_mask(int a);
    return (a == 0) ? 32'h0000_00F0 : 32'h0F0F_0000;
  endfunction
  function automatic logic [31:0] lo_mask(int a);
    return (a == 0) ? 32'h0000_000F : 32'hF0F0_FF00;
  endfunction

  // Vectors per R9
  function automatic logic [8:0] vec_of(int b);
    case (b)
      6:  return 9'o254;
      7:  return 9'o224;
      16: return 9'o340;
      17: return 9'o344;
      24: return 9'o070;
      25: return 9'o074;
      26: return 9'o754;
      default: return 9'o000;
    endcase
  endfunction

  // Level mask per R3
  function automatic logic [7:0] lvl_of(logic [31:0] p);
    logic [7:0] r = '0;
    for (int a = 0; a < 2; a++) begin
      if (((p & hi_mask(a)) != 0) && hl[a] != 0) r[hl[a]] = 1'b1;
      if (((p & lo_mask(a)) != 0) && ll[a] != 0) r[ll[a]] = 1'b1;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock cycle with full reference comparison.
  task automatic cycle(input logic [31:0] s, input logic [31:0] c,
                       input logic av, input logic [2:0] al);
    logic        hit = 0;
    int          adp = 0, idx = 0;
    logic [31:0] m = '0, aclr = '0;
    @(negedge clk);
    req_set = s; req_clr = c; ack_valid = av; ack_level = al;
    exp_lvl = lvl_of(m_pend);
    for (int a = 0; a < 2; a++) begin           // scan order per R6
      if (!hit && al != 0) begin
        if (hl[a] == al && (m_pend & hi_mask(a)) != 0) begin
          hit = 1; adp = a; m = m_pend & hi_mask(a);
        end else if (ll[a] == al && (m_pend & lo_mask(a)) != 0) begin
          hit = 1; adp = a; m = m_pend & lo_mask(a);
        end
      end
    end
    for (int i = 31; i >= 0; i--) if (m[i]) idx = i;   // R7 lowest wins
    exp_rv = av;
    if (av) begin
      exp_vec = hit ? vec_of(idx) : 9'd0;
      exp_adp = hit ? 2'(2 * adp + 1) : 2'd0;
      if (hit) aclr[idx] = 1'b1;
    end
    m_pend = (m_pend & ~c & ~aclr) | s;
    @(posedge clk); #1;
    chk(pending === m_pend, "R1/R2/R7 pending", pending, m_pend);
    chk(level_mask === exp_lvl, "R3 level_mask", {24'd0, level_mask}, {24'd0, exp_lvl});
    chk(rsp_valid === exp_rv, "R5 rsp_valid", {31'd0, rsp_valid}, {31'd0, exp_rv});
    if (exp_rv) begin
      chk(rsp_adapter === exp_adp, "R6/R8 adapter", {30'd0, rsp_adapter}, {30'd0, exp_adp});
      chk(rsp_vector === exp_vec, "R9 vector", {23'd0, rsp_vector}, {23'd0, exp_vec});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'h5EED_1234);
    rst = 1'b1; req_set = '0; req_clr = '0; ack_valid = 0; ack_level = 0;
    hl[0] = 0; hl[1] = 0; ll[0] = 0; ll[1] = 0;
    m_pend = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk(pending == 0, "R4 reset pending", pending, 0);
    chk(level_mask == 0, "R4 reset level_mask", {24'd0, level_mask}, 0);
    chk(rsp_valid == 0, "R4 reset rsp_valid", {31'd0, rsp_valid}, 0);

    // Directed: scan order and adapter numbering (R6, R8, R9)
    hl[0] = 5; ll[0] = 3; hl[1] = 5; ll[1] = 2;
    cycle(32'h0001_0040, 0, 0, 0);
    cycle(0, 0, 1, 5);
    chk(level_mask == 8'h20, "R3 hi level 5", {24'd0, level_mask}, 32'h20);
    chk(rsp_adapter == 2'd1 && rsp_vector == 9'o254, "R6 adapter0 first",
        {21'd0, rsp_adapter, rsp_vector}, {21'd0, 2'd1, 9'o254});
    cycle(0, 0, 1, 5);
    chk(rsp_adapter == 2'd3 && rsp_vector == 9'o340, "R8 adapter number 3",
        {21'd0, rsp_adapter, rsp_vector}, {21'd0, 2'd3, 9'o340});
    cycle(0, 0, 1, 5);
    chk(rsp_adapter == 0 && rsp_vector == 0, "R8 no match",
        {21'd0, rsp_adapter, rsp_vector}, 0);

    // Lowest bit wins (R7)
    cycle(32'h0502_0000, 0, 0, 0);
    cycle(0, 0, 1, 5);
    chk(rsp_vector == 9'o344, "R7 lowest bit", {23'd0, rsp_vector}, {23'd0, 9'o344});
    chk(pending == 32'h0500_0000, "R7 winner cleared", pending, 32'h0500_0000);
    // Set beats acknowledge clear (R1)
    cycle(32'h0100_0000, 0, 1, 5);
    chk(rsp_vector == 9'o070 && pending == 32'h0500_0000, "R1 set beats ack clear",
        pending, 32'h0500_0000);

    // Set and clear same cycle (R1), clear alone (R2)
    cycle(32'h8, 32'h8, 0, 0);
    chk(pending[3] == 1'b1, "R1 set over clear", pending, m_pend);
    cycle(0, 32'h8, 0, 0);
    chk(pending[3] == 1'b0, "R2 clear", pending, m_pend);

    // Level 0 is disconnected (R3, R6)
    cycle(0, 32'hFFFF_FFFF, 0, 0);
    ll[1] = 0;
    cycle(32'h100, 0, 0, 0);
    cycle(0, 0, 1, 0);
    chk(rsp_adapter == 0 && rsp_vector == 0 && pending == 32'h100,
        "R6 level zero never matches", pending, 32'h100);
    chk(level_mask == 0, "R3 field zero disconnected", {24'd0, level_mask}, 0);

    // Group membership (R10)
    cycle(0, 32'hFFFF_FFFF, 0, 0);
    hl[0] = 6; ll[0] = 3; hl[1] = 1; ll[1] = 7;
    cycle(32'h10, 0, 0, 0);
    cycle(0, 0, 0, 0);
    chk(level_mask == 8'h40, "R10 bit4 in adapter0 high", {24'd0, level_mask}, 32'h40);
    cycle(32'h1000_0001, 32'h10, 0, 0);
    cycle(0, 0, 0, 0);
    chk(level_mask == 8'h88, "R10 bits0/28 low groups", {24'd0, level_mask}, 32'h88);

    // Constrained random
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] s, c;
      if (k % 50 == 0) begin
        for (int a = 0; a < 2; a++) begin
          hl[a] = 3'($urandom_range(0, 7));
          ll[a] = ($urandom_range(0, 3) == 0) ? hl[a] : 3'($urandom_range(0, 7));
        end
      end
      s = $urandom & $urandom & $urandom;
      c = $urandom & $urandom & $urandom & $urandom;
      cycle(s, c, ($urandom_range(0, 2) == 0), 3'($urandom_range(0, 7)));
    end
    cycle(0, 0, 0, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule